// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives a stereo serial audio stream as a slave: the bit clock and the word-select line come from outside and are sampled in the system clock domain. A two-flop synchronizer and an edge detector sit in front of the deserializer. The deserializer frames each channel word and writes it, tagged with its channel, into a receive FIFO. The framing and the sample width are chosen at run time. Each sample is stored MSB-aligned in a 32-bit word.

The FIFO drains through a valid/ready stream port. `rd_valid` rises when enough words are stored for the selected read mode. A word leaves only in a cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` stays high and `rd_data` holds its value. No back-pressure reaches the serial side. A word that arrives while the FIFO is full is lost, and a sticky flag records the loss.

Status pins report the fill level and the empty, full, almost-empty and almost-full conditions. A request pin rises while the level is above a programmable limit. `DEPTH` must be a power of two.

Top module: `audio_rx_top`

## Requirements
- R1: `cfg_fmt` selects the framing: 0 = I2S (MSB one bit slot after the word-select change), 1 = left-justified (MSB in the first slot after the change), 2 = right-justified (sample in the last N slots before the next change; earlier bits are discarded).
- R2: `cfg_wsel` selects N: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. `rd_data` carries the sample in bits 31 down to 32-N, with the lower bits zero.
- R3: `sd_i` and `ws_i` are taken on rising edges of `bclk_i`. Word-select low marks the left channel (`rd_chan`=0) and high marks the right channel (`rd_chan`=1). Words leave in the order they arrived.
- R4: With `cfg_packed`=0, `rd_valid` is high whenever at least one word is stored, and each handshake removes exactly one word.
- R5: With `cfg_packed`=1, `rd_valid` is high only when at least two words are stored. `rd_data` is {older word bits 31:16, next word bits 31:16}, and each handshake removes both words.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change in the next cycle.
- R7: `level` equals the number of stored words (at most `DEPTH`). `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals `DEPTH`.
- R8: `almost_empty` is high when `level` <= `AE_LEVEL`. `almost_full` is high when `level` >= `DEPTH`-`AF_GAP`.
- R9: `req` is high exactly when `level` is greater than `cfg_limit`.
- R10: A word completed while the FIFO is full is dropped and sets `ovf`. `ovf` stays high until a cycle with `ovf_clr` high and no new drop.
- R11: After reset, `level` is 0, `rd_valid` is 0 and `ovf` is 0. The word that begins at the first word-select change after reset is discarded. Capture starts with the word that begins at the second change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External word-select (0 left, 1 right) |
| sd_i | input | 1 | Serial data |
| cfg_fmt | input | 2 | Framing select |
| cfg_wsel | input | 2 | Sample width select |
| cfg_packed | input | 1 | 1 = packed 16+16 read mode |
| cfg_limit | input | $clog2(DEPTH+1) | Request threshold |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_valid | output | 1 | Stream data available |
| rd_ready | input | 1 | Stream consumer ready |
| rd_data | output | 32 | Stream data |
| rd_chan | output | 1 | Channel of the head word |
| level | output | $clog2(DEPTH+1) | Stored word count |
| empty | output | 1 | FIFO empty |
| full | output | 1 | FIFO full |
| almost_empty | output | 1 | Level at or below AE_LEVEL |
| almost_full | output | 1 | Level at or above DEPTH-AF_GAP |
| req | output | 1 | Level above cfg_limit |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check the stream hold rule, the stickiness of the overflow flag, the level bound, and the change in level allowed after each kind of handshake, on every cycle. Bit alignment under each framing, the MSB alignment for each width, the channel tags, discarding of the start-up word, the packed layout and the dropping of words at overflow only show up in the bench's scenarios. In those scenarios, each serialized frame is compared with the queue of words the bench expects.

// File: rtl/audio_rx_pkg.sv
`timescale 1ns/1ps
package audio_rx_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                chan;
    logic [SAMPLE_W-1:0] data;
  } word_t;

  function automatic logic [5:0] width_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/audio_rx_sync.sv
`timescale 1ns/1ps
module audio_rx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/audio_rx_deser.sv
`timescale 1ns/1ps
module audio_rx_deser
  import audio_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       ws,
  input  logic       sd,
  input  logic [1:0] cfg_fmt,
  input  logic [1:0] cfg_wsel,
  output logic       push_v,
  output word_t      push_word
);
  fmt_e                fmt;
  logic [5:0]          nbits;
  logic [5:0]          sh_amt;
  logic                ws_last, eff_last, eff_ws, ws_edge, keep_bit;
  logic                armed, started;
  logic [5:0]          cnt;
  logic [SAMPLE_W-1:0] shreg, aligned;

  assign fmt      = fmt_e'(cfg_fmt);
  assign nbits    = width_bits(cfg_wsel);
  assign sh_amt   = 6'(SAMPLE_W) - nbits;
  // I2S runs one slot behind word-select, so use the previous slot's value
  assign eff_ws   = (fmt == FMT_I2S) ? ws_last : ws;
  assign ws_edge  = eff_ws ^ eff_last;
  // right-justified keeps a sliding window, the others stop after N bits
  assign keep_bit = (fmt == FMT_RJ) || (cnt < nbits);
  assign aligned  = shreg << sh_amt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_last   <= 1'b0;
      eff_last  <= 1'b0;
      armed     <= 1'b0;
      started   <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      push_v    <= 1'b0;
      push_word <= '0;
    end else begin
      push_v <= 1'b0;
      if (bit_tick) begin
        ws_last  <= ws;
        eff_last <= eff_ws;
        if (ws_edge) begin
          armed <= 1'b1;
          if (armed) started <= 1'b1;
          if (started) begin
            push_v         <= 1'b1;
            push_word.chan <= eff_last;
            push_word.data <= aligned;
          end
          shreg <= {{(SAMPLE_W-1){1'b0}}, sd};
          cnt   <= 6'd1;
        end else begin
          if (keep_bit) shreg <= {shreg[SAMPLE_W-2:0], sd};
          if (cnt != 6'h3f) cnt <= cnt + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_fifo.sv
`timescale 1ns/1ps
module audio_rx_fifo
  import audio_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  word_t                        wr_word,
  input  logic                         pop_one,
  input  logic                         pop_two,
  output word_t                        head,
  output logic [SAMPLE_W/2-1:0]        next_hi,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  word_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok;
  logic [1:0]    pop_n;

  assign wr_ok   = wr_en && (level != FULL_LVL);
  assign drop    = wr_en && (level == FULL_LVL);
  assign pop_n   = pop_two ? 2'd2 : (pop_one ? 2'd1 : 2'd0);
  assign head    = mem[rd_ptr];
  assign next_hi = mem[rd_ptr + AW'(1)].data[SAMPLE_W-1:SAMPLE_W/2];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + CW'(wr_ok) - CW'(pop_n);
    end
  end
endmodule

// File: rtl/audio_rx_status.sv
`timescale 1ns/1ps
module audio_rx_status #(
  parameter int DEPTH    = 8,
  parameter int AE_LEVEL = 1,
  parameter int AF_GAP   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_limit,
  input  logic                       drop,
  input  logic                       ovf_clr,
  output logic                       empty,
  output logic                       full,
  output logic                       almost_empty,
  output logic                       almost_full,
  output logic                       req,
  output logic                       ovf
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] AE_LVL   = CW'(AE_LEVEL);
  localparam logic [CW-1:0] AF_LVL   = CW'(DEPTH - AF_GAP);

  assign empty        = (level == '0);
  assign full         = (level == FULL_LVL);
  assign almost_empty = (level <= AE_LVL);
  assign almost_full  = (level >= AF_LVL);
  assign req          = (level > cfg_limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end
endmodule

// File: rtl/audio_rx_top.sv
`timescale 1ns/1ps
module audio_rx_top
  import audio_rx_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AE_LEVEL    = 1,
  parameter int AF_GAP      = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_i,
  input  logic                       ws_i,
  input  logic                       sd_i,
  input  logic [1:0]                 cfg_fmt,
  input  logic [1:0]                 cfg_wsel,
  input  logic                       cfg_packed,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_limit,
  input  logic                       ovf_clr,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [31:0]                rd_data,
  output logic                       rd_chan,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       empty,
  output logic                       full,
  output logic                       almost_empty,
  output logic                       almost_full,
  output logic                       req,
  output logic                       ovf
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] PAIR_LVL = CW'(2);

  logic [2:0]            sync_out;
  logic                  bclk_s, ws_s, sd_s, bclk_d, bit_tick;
  logic                  push_v, drop, take;
  word_t                 push_word, head;
  logic [SAMPLE_W/2-1:0] next_hi;

  audio_rx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({bclk_i, ws_i, sd_i}), .dout(sync_out)
  );
  assign {bclk_s, ws_s, sd_s} = sync_out;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s;
  end
  assign bit_tick = bclk_s & ~bclk_d;

  audio_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ws(ws_s), .sd(sd_s),
    .cfg_fmt(cfg_fmt), .cfg_wsel(cfg_wsel), .push_v(push_v), .push_word(push_word)
  );

  assign rd_valid = cfg_packed ? (level >= PAIR_LVL) : (level != '0);
  assign take     = rd_valid & rd_ready;
  assign rd_data  = cfg_packed ? {head.data[SAMPLE_W-1:SAMPLE_W/2], next_hi} : head.data;
  assign rd_chan  = head.chan;

  audio_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push_v), .wr_word(push_word),
    .pop_one(take & ~cfg_packed), .pop_two(take & cfg_packed),
    .head(head), .next_hi(next_hi), .level(level), .drop(drop)
  );

  audio_rx_status #(.DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .AF_GAP(AF_GAP)) u_status (
    .clk(clk), .rst_n(rst_n), .level(level), .cfg_limit(cfg_limit), .drop(drop),
    .ovf_clr(ovf_clr), .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full), .req(req), .ovf(ovf)
  );
endmodule

// File: rtl/audio_rx_chk.sv
`timescale 1ns/1ps
module audio_rx_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [31:0]                rd_data,
  input logic                       cfg_packed,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       ovf,
  input logic                       ovf_clr
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  assert_no_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> level >= $past(level));

  assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_packed && rd_valid && rd_ready |=> level <= $past(level));

  assert_pair_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_packed && rd_valid && rd_ready |=> level < $past(level));
endmodule

bind audio_rx_top audio_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .cfg_packed(cfg_packed), .level(level), .ovf(ovf),
  .ovf_clr(ovf_clr)
);

// File: tb/tb_audio_rx_top.sv
`timescale 1ns/1ps
module tb_audio_rx_top;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH+1);
  localparam int HALF  = 3;

  logic clk = 0, rst_n = 0;
  logic bclk_i = 0, ws_i = 0, sd_i = 0;
  logic [1:0] cfg_fmt = 0, cfg_wsel = 0;
  logic cfg_packed = 0, ovf_clr = 0, rd_ready = 0;
  logic [CW-1:0] cfg_limit = CW'(DEPTH);
  logic rd_valid, rd_chan, empty, full, almost_empty, almost_full, req, ovf;
  logic [31:0] rd_data;
  logic [CW-1:0] level;

  int total = 0, bad = 0;
  bit done = 0;
  logic [32:0] exp_q[$];

  always #5 clk = ~clk;

  audio_rx_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .cfg_fmt(cfg_fmt), .cfg_wsel(cfg_wsel), .cfg_packed(cfg_packed),
    .cfg_limit(cfg_limit), .ovf_clr(ovf_clr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_chan(rd_chan), .level(level),
    .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full), .req(req), .ovf(ovf)
  );

  task automatic check(input bit ok, input string tag, input logic [32:0] act,
                       input logic [32:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lv;
      lv = int'(level);
      check(empty == (lv == 0), "R7 empty", 33'(empty), 33'(lv == 0));
      check(full == (lv == DEPTH), "R7 full", 33'(full), 33'(lv == DEPTH));
      check(almost_empty == (lv <= 1), "R8 almost_empty", 33'(almost_empty), 33'(lv <= 1));
      check(almost_full == (lv >= DEPTH-1), "R8 almost_full", 33'(almost_full), 33'(lv >= DEPTH-1));
      check(req == (lv > int'(cfg_limit)), "R9 req", 33'(req), 33'(lv > int'(cfg_limit)));
      if (cfg_packed)
        check(rd_valid == (lv >= 2), "R5 valid", 33'(rd_valid), 33'(lv >= 2));
      else
        check(rd_valid == (lv >= 1), "R4 valid", 33'(rd_valid), 33'(lv >= 1));
      if (rd_valid && rd_ready) begin
        if (cfg_packed) begin
          if (exp_q.size() < 2) check(0, "R5 unexpected pair", 33'(rd_data), 33'h0);
          else begin
            logic [32:0] a, b;
            a = exp_q.pop_front();
            b = exp_q.pop_front();
            check(rd_data == {a[31:16], b[31:16]}, "R5 packed data",
                  33'(rd_data), {1'b0, a[31:16], b[31:16]});
          end
        end else begin
          if (exp_q.size() < 1) check(0, "R4 unexpected word", {rd_chan, rd_data}, 33'h0);
          else begin
            logic [32:0] a;
            a = exp_q.pop_front();
            check({rd_chan, rd_data} == a, "R1 R2 R3 word", {rd_chan, rd_data}, a);
          end
        end
      end
    end
  end

  task automatic sbit(input logic w, input logic d);
    bclk_i = 0; ws_i = w; sd_i = d;
    repeat (HALF) @(posedge clk); #1;
    bclk_i = 1;
    repeat (HALF) @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic [1:0] fmt, input logic [1:0] wsel,
                          input logic packed_md, input int limit);
    @(posedge clk); #1;
    rst_n = 0; ws_i = 0; sd_i = 0; bclk_i = 0; rd_ready = 0;
    cfg_fmt = fmt; cfg_wsel = wsel; cfg_packed = packed_md; cfg_limit = CW'(limit);
    repeat (4) @(posedge clk); #1;
    rst_n = 1;
    repeat (2) @(posedge clk); #1;
  endtask

  // sends a discarded start-up word, n stereo frames of 32-bit slots, then a closing edge
  task automatic burst(input int n);
    logic wq[$], dq[$];
    int nb;
    logic prev;
    nb = int'(cfg_wsel == 2'd0) * 16 + int'(cfg_wsel == 2'd1) * 20 +
         int'(cfg_wsel == 2'd2) * 24 + int'(cfg_wsel == 2'd3) * 32;
    for (int i = 0; i < 4; i++) begin wq.push_back(1'b1); dq.push_back(1'b0); end
    for (int f = 0; f < n; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [31:0] s;
        s = $urandom();
        if (nb < 32) s = s & ((32'd1 << nb) - 32'd1);
        exp_q.push_back({ch[0], s << (32 - nb)});
        for (int i = 0; i < 32; i++) begin
          wq.push_back(ch[0]);
          if (cfg_fmt == 2'd2) dq.push_back((i >= 32 - nb) ? s[31-i] : 1'b1);
          else                 dq.push_back((i < nb) ? s[nb-1-i] : 1'b0);
        end
      end
    end
    for (int i = 0; i < 4; i++) begin wq.push_back(1'b0); dq.push_back(1'b0); end
    prev = 1'b0;
    for (int k = 0; k < wq.size(); k++) begin
      if (cfg_fmt == 2'd0) begin sbit(wq[k], prev); prev = dq[k]; end
      else sbit(wq[k], dq[k]);
    end
    repeat (8) @(posedge clk); #1;
  endtask

  task automatic drain(input string tag);
    rd_ready = 1;
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || level != 0); i++) begin
      @(posedge clk); #1;
    end
    check(level == 0, tag, 33'(level), 33'h0);
    check(exp_q.size() == 0, tag, 33'(exp_q.size()), 33'h0);
  endtask

  initial begin
    logic [31:0] held;
    do_reset(2'd0, 2'd2, 1'b0, DEPTH);
    check(level == 0 && empty && !rd_valid && !ovf, "R11 reset state",
          {29'b0, level}, 33'h0);
    // word-select held low with data toggling: nothing may be captured
    for (int i = 0; i < 8; i++) sbit(1'b0, 1'b1);
    check(level == 0, "R11 no capture before ws changes", 33'(level), 33'h0);

    // I2S, 24-bit, streaming
    rd_ready = 1;
    burst(3);
    drain("R1 I2S drain");

    // left-justified, 16-bit
    do_reset(2'd1, 2'd0, 1'b0, DEPTH);
    rd_ready = 1;
    burst(3);
    drain("R1 LJ drain");

    // right-justified, 20-bit, back-pressured with junk leading bits
    do_reset(2'd2, 2'd1, 1'b0, 3);
    burst(3);
    check(level == 6, "R7 level after stall", 33'(level), 33'd6);
    check(req == 1'b1, "R9 req above limit", 33'(req), 33'd1);
    held = rd_data;
    repeat (3) @(posedge clk); #1;
    check(rd_valid && rd_data == held, "R6 hold while stalled", 33'(rd_data), 33'(held));
    drain("R1 RJ drain");

    // left-justified, 32-bit
    do_reset(2'd1, 2'd3, 1'b0, DEPTH);
    rd_ready = 1;
    burst(2);
    drain("R2 32-bit drain");

    // packed read mode
    do_reset(2'd1, 2'd0, 1'b1, DEPTH);
    rd_ready = 1;
    burst(3);
    drain("R5 packed drain");

    // overflow: 12 words into 8 entries
    do_reset(2'd0, 2'd0, 1'b0, 5);
    burst(6);
    while (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    check(level == CW'(DEPTH) && full, "R7 full after overflow", 33'(level), 33'(DEPTH));
    check(ovf == 1'b1, "R10 ovf set", 33'(ovf), 33'd1);
    check(req == 1'b1, "R9 req when full", 33'(req), 33'd1);
    drain("R10 drain kept words");
    check(ovf == 1'b1, "R10 ovf sticky", 33'(ovf), 33'd1);
    ovf_clr = 1;
    @(posedge clk); #1;
    ovf_clr = 0;
    @(posedge clk); #1;
    check(ovf == 1'b0, "R10 ovf cleared", 33'(ovf), 33'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule